// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Watchdog Interaction

This block decides which of a small microcontroller's clocks run at any moment. A WAIT strobe parks the CPU while the peripheral timer keeps ticking. A STOP strobe parks everything. The static halt option turns STOP into a halt instead, which keeps the oscillator and watchdog alive. Interrupt requests and reset bring the CPU back. Leaving a wait is immediate. Leaving a stop or halt first holds the CPU off for a fixed oscillator-settling window.

A free-running watchdog counter runs alongside the mode logic and is cleared by a service strobe. If it is left unserviced it raises a one-cycle reset pulse and sends the controller through the settling window back to run. The watchdog is held cleared while in true stop, because no clock reaches it there. For this reason the halt option should be chosen whenever the watchdog is enabled.

All outputs are registered and change together with the mode code. The mode codes are run = 0, wait = 1, stop = 2, halt = 3 and settle = 4.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst` is high, the next clock edge gives mode 0 with `cpu_clk_en`, `tmr_clk_en` and `osc_run` high, and with `imask_clr` and `wdog_rst` low.
- R2: In run mode, `wait_stb` gives mode 1 on the next edge, with `cpu_clk_en` low and both `tmr_clk_en` and `osc_run` high.
- R3: `imask_clr` is high for exactly the first cycle of each stay in wait mode and is low at all other times.
- R4: In wait mode, `tmr_irq`, `ext_irq`, or `port_irq` with `opt_port_wake` high returns the block to mode 0 on the next edge with `cpu_clk_en` high. There is no settling delay.
- R5: When `opt_port_wake` is low, `port_irq` has no effect in wait, stop or halt mode.
- R6: In run mode, `stop_stb` gives mode 3 (`osc_run` high, CPU and timer clocks low) when `opt_halt` is high, and mode 2 (all three enables low) when `opt_halt` is low.
- R7: `tmr_irq` does not wake the block from stop or halt mode.
- R8: In stop or halt mode, `ext_irq`, or `port_irq` with `opt_port_wake` high, gives mode 4 for exactly SETTLE_CYCLES cycles, with `cpu_clk_en` low and `osc_run` high. Mode 0 follows.
- R9: When `opt_wdog_en` is high and the watchdog has not been serviced, `wdog_rst` pulses for one cycle exactly WDOG_LIMIT edges after the edge that sampled the last `wdog_kick`. In that same cycle the mode becomes 4, and mode 0 follows after the settling window.
- R10: The watchdog keeps counting in wait and halt mode, so an unserviced watchdog fires from either mode.
- R11: The watchdog never fires in stop mode, and it never fires while `opt_wdog_en` is low.
- R12: `rst` overrides every mode, including the settling window, and gives mode 0 with `cpu_clk_en` high on the next edge.
- R13: If `wait_stb` and `stop_stb` arrive together in run mode, wait wins. Either strobe is ignored when the block is not in run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_stb | input | 1 | WAIT instruction strobe |
| stop_stb | input | 1 | STOP instruction strobe |
| tmr_irq | input | 1 | Enabled interrupt request from the timer |
| ext_irq | input | 1 | External interrupt request |
| port_irq | input | 1 | Port interrupt request |
| opt_halt | input | 1 | Static option: STOP becomes halt |
| opt_wdog_en | input | 1 | Static option: watchdog enabled |
| opt_port_wake | input | 1 | Static option: port interrupt may wake |
| wdog_kick | input | 1 | Watchdog service strobe |
| cpu_clk_en | output | 1 | CPU and bus clock enable |
| tmr_clk_en | output | 1 | Peripheral timer clock enable |
| osc_run | output | 1 | Keep the oscillator running |
| imask_clr | output | 1 | One-cycle clear of the interrupt-mask bit |
| wdog_rst | output | 1 | One-cycle watchdog reset pulse |
| mode | output | 3 | Current mode code |

## Verification
Every output is a registered function of the mode register, so a wrong state shows on the clock enables and on `mode` one edge after the event that caused it. A settle counter that loads the wrong value is different: it only shows when `cpu_clk_en` returns early or late, SETTLE_CYCLES cycles later. A mistake in the watchdog's width or limit, or a counter that runs in stop mode, only shows when `wdog_rst` fires at the wrong edge. That takes a full WDOG_LIMIT window, so the bench counts edges from the last service strobe.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    MODE_RUN    = 3'd0,
    MODE_WAIT   = 3'd1,
    MODE_STOP   = 3'd2,
    MODE_HALT   = 3'd3,
    MODE_SETTLE = 3'd4
  } mode_t;

  // {cpu clock, timer clock, oscillator} for each mode
  function automatic logic [2:0] clk_set(mode_t m);
    case (m)
      MODE_RUN:    return 3'b111;
      MODE_WAIT:   return 3'b011;
      MODE_STOP:   return 3'b000;
      MODE_HALT:   return 3'b001;
      MODE_SETTLE: return 3'b001;
      default:     return 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/lpm_wake_decode.sv
module lpm_wake_decode (
  input  logic tmr_irq,
  input  logic ext_irq,
  input  logic port_irq,
  input  logic opt_port_wake,
  output logic wake_from_wait,
  output logic wake_from_stop
);
  logic port_ok;

  assign port_ok        = port_irq & opt_port_wake;
  // the timer clock is gated in stop/halt, so only wait listens to it
  assign wake_from_wait = tmr_irq | ext_irq | port_ok;
  assign wake_from_stop = ext_irq | port_ok;
endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
  parameter int SETTLE_CYCLES = 4064
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic active,
  output logic done
);
  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= RELOAD;
    else if (active && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign done = active && (cnt == '0);
endmodule

// File: rtl/lpm_watchdog.sv
module lpm_watchdog #(
  parameter int WDOG_LIMIT = 16384
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic hold,
  input  logic kick,
  output logic fire
);
  localparam int WW = (WDOG_LIMIT > 1) ? $clog2(WDOG_LIMIT) : 1;
  localparam logic [WW-1:0] LAST = WW'(WDOG_LIMIT - 1);

  logic [WW-1:0] cnt;

  assign fire = enable && !hold && !kick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !enable || hold || kick || fire)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4064,
  parameter int WDOG_LIMIT    = 16384
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wait_stb,
  input  logic       stop_stb,
  input  logic       tmr_irq,
  input  logic       ext_irq,
  input  logic       port_irq,
  input  logic       opt_halt,
  input  logic       opt_wdog_en,
  input  logic       opt_port_wake,
  input  logic       wdog_kick,
  output logic       cpu_clk_en,
  output logic       tmr_clk_en,
  output logic       osc_run,
  output logic       imask_clr,
  output logic       wdog_rst,
  output logic [2:0] mode
);
  mode_t      mode_q, mode_d;
  logic       wake_w, wake_s;
  logic       wd_fire, settle_done, enter_settle;
  logic [2:0] clk_q;
  logic       imask_q, wdrst_q;

  lpm_wake_decode u_wake (
    .tmr_irq        (tmr_irq),
    .ext_irq        (ext_irq),
    .port_irq       (port_irq),
    .opt_port_wake  (opt_port_wake),
    .wake_from_wait (wake_w),
    .wake_from_stop (wake_s)
  );

  lpm_watchdog #(.WDOG_LIMIT(WDOG_LIMIT)) u_wdog (
    .clk    (clk),
    .rst    (rst),
    .enable (opt_wdog_en),
    .hold   (mode_q == MODE_STOP),
    .kick   (wdog_kick),
    .fire   (wd_fire)
  );

  lpm_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk    (clk),
    .rst    (rst),
    .load   (enter_settle),
    .active (mode_q == MODE_SETTLE),
    .done   (settle_done)
  );

  always_comb begin
    mode_d       = mode_q;
    enter_settle = 1'b0;
    if (wd_fire) begin
      mode_d       = MODE_SETTLE;
      enter_settle = 1'b1;
    end else begin
      case (mode_q)
        MODE_RUN: begin
          if (wait_stb)
            mode_d = MODE_WAIT;
          else if (stop_stb)
            mode_d = opt_halt ? MODE_HALT : MODE_STOP;
        end
        MODE_WAIT: begin
          if (wake_w)
            mode_d = MODE_RUN;
        end
        MODE_STOP, MODE_HALT: begin
          if (wake_s) begin
            mode_d       = MODE_SETTLE;
            enter_settle = 1'b1;
          end
        end
        MODE_SETTLE: begin
          if (settle_done)
            mode_d = MODE_RUN;
        end
        default: mode_d = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_RUN;
      clk_q   <= 3'b111;
      imask_q <= 1'b0;
      wdrst_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      clk_q   <= clk_set(mode_d);
      imask_q <= (mode_d == MODE_WAIT) && (mode_q != MODE_WAIT);
      wdrst_q <= wd_fire;
    end
  end

  assign cpu_clk_en = clk_q[2];
  assign tmr_clk_en = clk_q[1];
  assign osc_run    = clk_q[0];
  assign imask_clr  = imask_q;
  assign wdog_rst   = wdrst_q;
  assign mode       = mode_q;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
  import lpm_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4064
) (
  input logic       clk,
  input logic       rst,
  input logic       wait_stb,
  input logic       ext_irq,
  input logic       port_irq,
  input logic       opt_port_wake,
  input logic       cpu_clk_en,
  input logic       imask_clr,
  input logic       wdog_rst,
  input logic [2:0] mode
);
  int prior_q;
  int elapsed;

  assign elapsed = wdog_rst ? 1 : prior_q + 1;

  always_ff @(posedge clk) begin
    if (rst)
      prior_q <= 0;
    else
      prior_q <= (mode == MODE_SETTLE) ? elapsed : 0;
  end

  AST_RST_RUN: assert property (@(posedge clk)
    rst |=> (mode == MODE_RUN) && cpu_clk_en); // R12

  AST_WAIT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RUN && wait_stb) |=> (mode == MODE_WAIT) || wdog_rst); // R2

  AST_IMASK_ONE: assert property (@(posedge clk) disable iff (rst)
    imask_clr |=> !imask_clr); // R3

  AST_IMASK_WAIT: assert property (@(posedge clk) disable iff (rst)
    imask_clr |-> (mode == MODE_WAIT)); // R3

  AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_WAIT && ext_irq) |=> (mode == MODE_RUN) || wdog_rst); // R4

  AST_STOP_STAYS: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_STOP && !ext_irq && !(port_irq && opt_port_wake))
      |=> (mode == MODE_STOP)); // R7

  AST_STOP_NO_WDOG: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_STOP) |=> !wdog_rst); // R11

  AST_WDOG_ONE: assert property (@(posedge clk) disable iff (rst)
    wdog_rst |=> !wdog_rst); // R9

  AST_WDOG_SETTLE: assert property (@(posedge clk) disable iff (rst)
    wdog_rst |-> (mode == MODE_SETTLE)); // R9

  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SETTLE && elapsed < SETTLE_CYCLES) |=> (mode == MODE_SETTLE)); // R8

  AST_SETTLE_END: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SETTLE && elapsed == SETTLE_CYCLES) |=> (mode == MODE_RUN) || wdog_rst); // R8
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wait_stb      (wait_stb),
  .ext_irq       (ext_irq),
  .port_irq      (port_irq),
  .opt_port_wake (opt_port_wake),
  .cpu_clk_en    (cpu_clk_en),
  .imask_clr     (imask_clr),
  .wdog_rst      (wdog_rst),
  .mode          (mode)
);

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;
  localparam int NSET = 20;
  localparam int LIM  = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wait_stb = 0, stop_stb = 0, tmr_irq = 0, ext_irq = 0, port_irq = 0;
  logic opt_halt = 0, opt_wdog_en = 0, opt_port_wake = 0, wdog_kick = 0;
  logic cpu_clk_en, tmr_clk_en, osc_run, imask_clr, wdog_rst;
  logic [2:0] mode;

  always #5 clk = ~clk;

  lpm_ctrl #(.SETTLE_CYCLES(NSET), .WDOG_LIMIT(LIM)) u0 (
    .clk(clk), .rst(rst), .wait_stb(wait_stb), .stop_stb(stop_stb),
    .tmr_irq(tmr_irq), .ext_irq(ext_irq), .port_irq(port_irq),
    .opt_halt(opt_halt), .opt_wdog_en(opt_wdog_en), .opt_port_wake(opt_port_wake),
    .wdog_kick(wdog_kick), .cpu_clk_en(cpu_clk_en), .tmr_clk_en(tmr_clk_en),
    .osc_run(osc_run), .imask_clr(imask_clr), .wdog_rst(wdog_rst), .mode(mode)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // [13:7] wait,stop,tmr,ext,port,halt,pwake  [6:4] mode  [3:1] cpu,tmr,osc  [0] imask
  localparam logic [13:0] VEC [14] = '{
    14'b0000000_000_111_0,  // idle in run
    14'b1000000_001_011_1,  // R2 R3 enter wait
    14'b0000100_001_011_0,  // R5 port ignored
    14'b0010000_000_111_0,  // R4 timer wake
    14'b1000000_001_011_1,  // R2
    14'b0001000_000_111_0,  // R4 ext wake
    14'b1000000_001_011_1,  // R3
    14'b0000101_000_111_0,  // R4 port wake enabled
    14'b1100000_001_011_1,  // R13 wait beats stop
    14'b0100000_001_011_0,  // R13 stop ignored in wait
    14'b0001000_000_111_0,  // R4
    14'b0100010_011_001_0,  // R6 halt
    14'b0010010_011_001_0,  // R7 timer ignored in halt
    14'b1000010_011_001_0   // R13 wait ignored in halt
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic clear_in();
    wait_stb = 0; stop_stb = 0; tmr_irq = 0; ext_irq = 0; port_irq = 0; wdog_kick = 0;
  endtask

  // called right after the edge that entered settle
  task automatic run_settle(input string tag);
    bit ok = 1;
    for (int i = 1; i <= NSET; i++) begin
      if (!(mode == 3'd4 && !cpu_clk_en && osc_run)) ok = 0;
      tick();
    end
    chk(ok, {tag, " settle window"}, int'(mode), 4);
    chk(mode == 3'd0 && cpu_clk_en, {tag, " run after settle"}, int'(mode), 0);
  endtask

  task automatic count_fire(output int n);
    n = 0;
    while (!wdog_rst && n < LIM + 10) begin
      tick();
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    bit ok;
    #2;
    tick();
    tick();
    chk(mode == 3'd0 && cpu_clk_en && tmr_clk_en && osc_run && !imask_clr && !wdog_rst,
        "R1 reset state", int'(mode), 0);
    rst = 0;

    foreach (VEC[k]) begin
      {wait_stb, stop_stb, tmr_irq, ext_irq, port_irq, opt_halt, opt_port_wake} = VEC[k][13:7];
      tick();
      clear_in();
      chk(mode == VEC[k][6:4], $sformatf("R2/R4/R6/R13 vec %0d mode", k), int'(mode), int'(VEC[k][6:4]));
      chk({cpu_clk_en, tmr_clk_en, osc_run} == VEC[k][3:1], $sformatf("R2/R6 vec %0d clocks", k),
          int'({cpu_clk_en, tmr_clk_en, osc_run}), int'(VEC[k][3:1]));
      chk(imask_clr == VEC[k][0], $sformatf("R3 vec %0d imask", k), int'(imask_clr), int'(VEC[k][0]));
    end

    // halt exit via external irq
    ext_irq = 1; tick(); clear_in();
    run_settle("R8 halt exit");

    // true stop, port wake
    opt_halt = 0; opt_port_wake = 1;
    stop_stb = 1; tick(); clear_in();
    chk(mode == 3'd2 && !osc_run && !tmr_clk_en, "R6 true stop", int'(mode), 2);
    port_irq = 1; tick(); clear_in();
    run_settle("R8 stop exit");
    opt_port_wake = 0;

    // R5 port ignored in stop
    stop_stb = 1; tick(); clear_in();
    port_irq = 1; tick(); tick(); port_irq = 0;
    chk(mode == 3'd2, "R5 port ignored in stop", int'(mode), 2);
    ext_irq = 1; tick(); clear_in();
    run_settle("R8 stop ext exit");

    // watchdog on
    opt_wdog_en = 1;
    rst = 1; tick(); rst = 0;
    ok = 1;
    for (int i = 0; i < 3 * LIM; i++) begin
      wdog_kick = (i % 50 == 0);
      tick();
      if (wdog_rst) ok = 0;
    end
    clear_in();
    chk(ok, "R9 serviced watchdog quiet", 1, 0);

    // R9 fire from run
    wdog_kick = 1; tick(); clear_in();
    count_fire(n);
    chk(n == LIM, "R9 fire timing in run", n, LIM);
    chk(mode == 3'd4, "R9 fire enters settle", int'(mode), 4);
    tick();
    chk(!wdog_rst, "R9 single pulse", int'(wdog_rst), 0);
    for (int i = 2; i < NSET; i++) tick();
    tick();
    chk(mode == 3'd0, "R9 run after settle", int'(mode), 0);

    // R10 fire in wait
    wdog_kick = 1; wait_stb = 1; tick(); clear_in();
    count_fire(n);
    chk(n == LIM, "R10 fire timing in wait", n, LIM);
    chk(mode == 3'd4, "R10 wait fire mode", int'(mode), 4);
    run_settle("R10 wait fire");

    // R10 fire in halt
    opt_halt = 1;
    wdog_kick = 1; stop_stb = 1; tick(); clear_in();
    chk(mode == 3'd3, "R10 in halt", int'(mode), 3);
    count_fire(n);
    chk(n == LIM, "R10 fire timing in halt", n, LIM);
    run_settle("R10 halt fire");

    // R11 no fire in stop
    opt_halt = 0;
    wdog_kick = 1; stop_stb = 1; tick(); clear_in();
    ok = 1;
    for (int i = 0; i < 3 * LIM; i++) begin
      tick();
      if (wdog_rst || mode != 3'd2) ok = 0;
    end
    chk(ok, "R11 quiet in stop", int'(mode), 2);
    ext_irq = 1; wdog_kick = 1; tick(); clear_in();
    run_settle("R11 stop exit");

    // R11 disabled watchdog never fires
    opt_wdog_en = 0;
    rst = 1; tick(); rst = 0;
    ok = 1;
    for (int i = 0; i < 3 * LIM; i++) begin
      tick();
      if (wdog_rst) ok = 0;
    end
    chk(ok, "R11 disabled watchdog", 1, 0);

    // R12 reset during settle and during wait
    opt_halt = 1;
    stop_stb = 1; tick(); clear_in();
    ext_irq = 1; tick(); clear_in();
    tick(); tick();
    rst = 1; tick(); rst = 0;
    chk(mode == 3'd0 && cpu_clk_en, "R12 reset in settle", int'(mode), 0);
    wait_stb = 1; tick(); clear_in();
    rst = 1; tick(); rst = 0;
    chk(mode == 3'd0 && cpu_clk_en && !imask_clr, "R12 reset in wait", int'(mode), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule